// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block sits between a host-side request port and a serial NOR flash device. The host gives one operation code, a 24-bit address and a length. The block checks the request first: it rejects a zero length, a page program that would cross a 256-byte page, and an erase whose address is not aligned to the erase size. A rejected request never touches the bus. An accepted request becomes the full byte sequence on a mode 0 SPI link: opcode, then the address with its most significant byte first, then the data. Chip select stays low across the whole command.

Read bytes leave on a byte-wide valid/ready stream. Program bytes arrive on a second stream. When the read stream is not ready, the block stops SCK between bytes. A polling operation reads status register 1 at a fixed spacing until the busy flag clears, and fails after a configurable number of reads. Every request ends with a single-cycle done pulse that carries a result code.

Top module: `nor_seq`

## Requirements
- R1: `req_op` selects the command byte: 0 ID read (0x90), 1 status 1 (0x05), 2 status 2 (0x35), 3 write enable (0x06), 4 read (0x03), 5 page program (0x02), 6 4 KiB erase (0x20), 7 32 KiB erase (0x52), 8 64 KiB erase (0xD8), 9 chip erase (0xC7), 10 busy poll (0x05). The command byte is always the first byte on MOSI.
- R2: ID read, read, program and the three sized erases send the address right after the command byte, as three bytes: bits 23:16, then 15:8, then 7:0. ID read sends three 0x00 bytes in place of the address.
- R3: `cs_n` falls once per command (once per status read when polling). It stays low for every byte of that command and rises only after the last byte. It is high whenever `req_ready` is high.
- R4: A page program whose address bits 7:0 plus `req_len` exceed 256 is rejected with result 2. Chip select does not fall.
- R5: An erase whose address is not a multiple of its size (4096, 32768 or 65536) is rejected with result 3. Chip select does not fall.
- R6: A read or page program with `req_len` equal to 0 is rejected with result 1. Chip select does not fall.
- R7: Data phases that read drive 0xFF on MOSI. Each received byte appears on `rd_data`/`rd_valid`: `req_len` bytes for a read, two (manufacturer, then device) for an ID read, and one for a status read. In status register 1, bit 0 is busy and bit 1 is the write-enable latch.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value and SCK stays low.
- R9: A page program takes its data bytes from `wr_data` on `wr_valid`/`wr_ready` handshakes and sends them in arrival order after the address.
- R10: A busy poll reads status register 1 in one chip-select frame per read, with `POLL_GAP` idle cycles between frames. It ends with result 0 on the first read whose bit 0 is clear. It ends with result 4 after `POLL_MAX` reads that all show busy. Poll reads do not appear on the read stream.
- R11: SPI mode 0. SCK idles low. MOSI changes only while SCK is low. MISO is sampled as SCK rises. One SCK period is `sck_div` clock cycles, where `sck_div` is even and at least 2 (6 is the intended setting).
- R12: A request is taken only when `req_valid` and `req_ready` are both high. `req_valid` has no effect while a command is in flight. `done` is high for exactly one cycle per accepted request, with `err` valid in that cycle. An `req_op` above 10 gives result 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_div | input | 8 | SCK period in clock cycles (even, at least 2) |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Idle and able to take a request |
| req_op | input | 4 | Operation code |
| req_addr | input | 24 | Flash byte address |
| req_len | input | 16 | Byte count for read or program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 3 | Result: 0 ok, 1 length, 2 page, 3 align, 4 timeout, 5 bad op |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer accepts received byte |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program byte available |
| wr_ready | output | 1 | Block takes program byte |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |
| cs_n | output | 1 | SPI chip select, active low |

## Verification
The protocol assertions assume `sck_div` is even, at least 2, and never changes while a command runs. The bench sets it only between commands, to 6 or 4. They also assume the host holds `req_op`, `req_addr` and `req_len` steady in the accepting cycle. The bench drives a request for exactly one cycle, on a falling clock edge, after it sees `req_ready`. The flash model answers on MISO only while chip select is low, and it changes MISO on falling SCK edges. The read consumer is free to hold `rd_ready` low for long stretches to exercise the stall.

// File: rtl/nor_seq_pkg.sv
// Shared operation and result codes for the flash command sequencer.
// Assumes a 24-bit flash address space with 256-byte program pages.
package nor_seq_pkg;
    localparam int ADDR_W = 24;
    localparam int PAGE_W = 8;

    localparam logic [3:0] OP_ID     = 4'd0;
    localparam logic [3:0] OP_STAT1  = 4'd1;
    localparam logic [3:0] OP_STAT2  = 4'd2;
    localparam logic [3:0] OP_WREN   = 4'd3;
    localparam logic [3:0] OP_READ   = 4'd4;
    localparam logic [3:0] OP_PROG   = 4'd5;
    localparam logic [3:0] OP_ER4K   = 4'd6;
    localparam logic [3:0] OP_ER32K  = 4'd7;
    localparam logic [3:0] OP_ER64K  = 4'd8;
    localparam logic [3:0] OP_ERCHIP = 4'd9;
    localparam logic [3:0] OP_POLL   = 4'd10;

    localparam logic [2:0] RES_OK      = 3'd0;
    localparam logic [2:0] RES_LEN     = 3'd1;
    localparam logic [2:0] RES_PAGE    = 3'd2;
    localparam logic [2:0] RES_ALIGN   = 3'd3;
    localparam logic [2:0] RES_TIMEOUT = 3'd4;
    localparam logic [2:0] RES_BADOP   = 3'd5;

    // Command byte sent first for each operation
    function automatic logic [7:0] cmd_byte(input logic [3:0] op);
        case (op)
            OP_ID:     return 8'h90;
            OP_STAT1:  return 8'h05;
            OP_STAT2:  return 8'h35;
            OP_WREN:   return 8'h06;
            OP_READ:   return 8'h03;
            OP_PROG:   return 8'h02;
            OP_ER4K:   return 8'h20;
            OP_ER32K:  return 8'h52;
            OP_ER64K:  return 8'hD8;
            OP_ERCHIP: return 8'hC7;
            OP_POLL:   return 8'h05;
            default:   return 8'hFF;
        endcase
    endfunction

    // True when the command carries a three-byte address field
    function automatic logic has_addr(input logic [3:0] op);
        return (op == OP_ID) || (op == OP_READ) || (op == OP_PROG) ||
               (op == OP_ER4K) || (op == OP_ER32K) || (op == OP_ER64K);
    endfunction
endpackage

// File: rtl/nor_seq_reqchk.sv
// Request validation: decides, before any bus activity, whether a
// request is legal. Purely combinational; assumes stable inputs.
module nor_seq_reqchk
    import nor_seq_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int SEC_W  = 12,
    parameter int B32_W  = 15,
    parameter int B64_W  = 16
) (
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic [2:0]        code
);
    localparam int SUM_W = LEN_W + 1;
    localparam logic [SUM_W-1:0] PAGE_BYTES = SUM_W'(1 << PAGE_W);

    logic [SUM_W-1:0] end_off;

    // Page offset plus length, wide enough not to wrap
    always_comb end_off = SUM_W'(addr[PAGE_W-1:0]) + SUM_W'(len);

    // Result code selection per operation
    always_comb begin
        code = RES_OK;
        case (op)
            OP_READ:  if (len == '0) code = RES_LEN;
            OP_PROG:  if (len == '0) code = RES_LEN;
                      else if (end_off > PAGE_BYTES) code = RES_PAGE;
            OP_ER4K:  if (addr[SEC_W-1:0] != '0) code = RES_ALIGN;
            OP_ER32K: if (addr[B32_W-1:0] != '0) code = RES_ALIGN;
            OP_ER64K: if (addr[B64_W-1:0] != '0) code = RES_ALIGN;
            OP_ID, OP_STAT1, OP_STAT2, OP_WREN, OP_ERCHIP, OP_POLL: code = RES_OK;
            default:  code = RES_BADOP;
        endcase
    end
endmodule

// File: rtl/nor_seq_shift.sv
// One-byte SPI mode 0 shifter. Assumes div is even and at least 2, and
// stays constant during a byte. MSB first; MISO is sampled as SCK rises
// and the next MOSI bit is presented as SCK falls.
module nor_seq_shift #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       tx,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             fin,
    output logic [7:0]       rx
);
    logic [DIV_W-1:0] half, cnt;
    logic [7:0]       sr;
    logic [2:0]       bitn;

    // Half SCK period in clock cycles, never below one
    always_comb half = ((div >> 1) == '0) ? DIV_W'(1) : (div >> 1);

    // Bit timing, shifting and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0; rx <= '0; cnt <= '0; bitn <= '0;
            sck <= 1'b0; busy <= 1'b0; fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!busy && start) begin
                sr <= tx; busy <= 1'b1; cnt <= '0; bitn <= '0; sck <= 1'b0;
            end else if (busy) begin
                if (cnt == half - 1'b1) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck <= 1'b1;
                        rx  <= {rx[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bitn == 3'd7) begin
                            busy <= 1'b0; fin <= 1'b1;
                        end else begin
                            bitn <= bitn + 1'b1;
                            sr   <= {sr[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Current bit on the line
    always_comb mosi = sr[7];
endmodule

// File: rtl/nor_seq.sv
// Flash command sequencer top. Takes one request while idle, validates it,
// then walks command, address and data bytes under one chip-select frame.
// Assumes request fields are stable in the accepting cycle and that
// sck_div changes only while idle.
module nor_seq
    import nor_seq_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int DIV_W    = 8,
    parameter int POLL_MAX = 1000,
    parameter int POLL_GAP = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  sck_div,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              done,
    output logic [2:0]        err,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int IDX_W  = LEN_W + 1;
    localparam int PCNT_W = $clog2(POLL_MAX + 1);
    localparam int GAP_W  = $clog2(POLL_GAP + 1);

    typedef enum logic [2:0] {S_IDLE, S_LOAD, S_XFER, S_END, S_WAIT} st_e;

    st_e               st;
    logic [3:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx, tot;
    logic [PCNT_W-1:0] pcnt;
    logic [GAP_W-1:0]  gap;
    logic [2:0]        chk_code;
    logic [2:0]        hdr;
    logic [IDX_W-1:0]  data_n;
    logic              in_data, is_wr, to_stream, go, start;
    logic [7:0]        tx_byte, rx_byte;
    logic              sh_busy, sh_fin;

    nor_seq_reqchk #(.LEN_W(LEN_W)) u_chk (
        .op(req_op), .addr(req_addr), .len(req_len), .code(chk_code)
    );

    nor_seq_shift #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .tx(tx_byte), .div(sck_div),
        .miso(miso), .sck(sck), .mosi(mosi), .busy(sh_busy), .fin(sh_fin),
        .rx(rx_byte)
    );

    // Frame size of the incoming request: header bytes plus data bytes
    always_comb begin
        hdr = has_addr(req_op) ? 3'd4 : 3'd1;
        case (req_op)
            OP_READ, OP_PROG:            data_n = IDX_W'(req_len);
            OP_ID:                       data_n = IDX_W'(2);
            OP_STAT1, OP_STAT2, OP_POLL: data_n = IDX_W'(1);
            default:                     data_n = '0;
        endcase
    end

    // Byte to send at the current position in the frame
    always_comb begin
        in_data   = idx >= (has_addr(op_q) ? IDX_W'(4) : IDX_W'(1));
        is_wr     = (op_q == OP_PROG);
        to_stream = in_data && !is_wr && (op_q != OP_POLL);
        if (idx == '0)      tx_byte = cmd_byte(op_q);
        else if (!in_data)  tx_byte = (idx == IDX_W'(1)) ? addr_q[23:16] :
                                      (idx == IDX_W'(2)) ? addr_q[15:8] : addr_q[7:0];
        else if (is_wr)     tx_byte = wr_data;
        else                tx_byte = 8'hFF;
    end

    // Launch and stream handshakes
    always_comb begin
        go        = !rd_valid && (!(in_data && is_wr) || wr_valid);
        start     = (st == S_LOAD) && go;
        wr_ready  = (st == S_LOAD) && in_data && is_wr && !rd_valid;
        req_ready = (st == S_IDLE) && !rd_valid;
    end

    // Command sequencing, polling and result reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; op_q <= '0; addr_q <= '0; idx <= '0; tot <= '0;
            pcnt <= '0; gap <= '0; cs_n <= 1'b1; done <= 1'b0; err <= RES_OK;
            rd_data <= '0; rd_valid <= 1'b0;
        end else begin
            done <= 1'b0;
            if (rd_valid && rd_ready) rd_valid <= 1'b0;
            case (st)
                S_IDLE: if (req_valid && req_ready) begin
                    if (chk_code != RES_OK) begin
                        done <= 1'b1; err <= chk_code;
                    end else begin
                        op_q   <= req_op;
                        addr_q <= (req_op == OP_ID) ? '0 : req_addr;
                        tot    <= IDX_W'(hdr) + data_n;
                        idx    <= '0; pcnt <= '0;
                        cs_n   <= 1'b0; st <= S_LOAD;
                    end
                end
                S_LOAD: if (go) st <= S_XFER;
                S_XFER: if (sh_fin) begin
                    if (to_stream) begin
                        rd_data <= rx_byte; rd_valid <= 1'b1;
                    end
                    if (idx == tot - 1'b1) begin
                        cs_n <= 1'b1; st <= S_END;
                    end else begin
                        idx <= idx + 1'b1; st <= S_LOAD;
                    end
                end
                S_END: begin
                    if ((op_q == OP_POLL) && rx_byte[0]) begin
                        if (pcnt == PCNT_W'(POLL_MAX - 1)) begin
                            done <= 1'b1; err <= RES_TIMEOUT; st <= S_IDLE;
                        end else begin
                            pcnt <= pcnt + 1'b1; gap <= '0; st <= S_WAIT;
                        end
                    end else begin
                        done <= 1'b1; err <= RES_OK; st <= S_IDLE;
                    end
                end
                S_WAIT: begin
                    if (gap == GAP_W'(POLL_GAP - 1)) begin
                        idx <= '0; cs_n <= 1'b0; st <= S_LOAD;
                    end else begin
                        gap <= gap + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nor_seq_sva.sv
// Protocol checker for nor_seq, attached by bind. Observes ports only.
module nor_seq_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic       wr_ready,
    input logic       sck,
    input logic       mosi,
    input logic       cs_n
);
    // R3
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);

    // R11
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R11
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R8
    rd_stall_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !sck) |=> !sck);

    // R12
    idle_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !wr_ready);
endmodule

bind nor_seq nor_seq_sva u_sva (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_ready(wr_ready), .sck(sck), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/nor_seq_tb.sv
// Directed bench for nor_seq with a small behavioural flash model.
module nor_seq_tb;
    import nor_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sck_div = 8'd6;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        done;
    logic [2:0]  err;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_ready;
    logic [7:0]  wr_data;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic        sck, mosi, cs_n;
    logic        miso = 1'b1;

    always #5 clk = ~clk;

    nor_seq #(.POLL_MAX(5), .POLL_GAP(20)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck_div(sck_div), .req_valid(req_valid),
        .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
        .req_len(req_len), .done(done), .err(err), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    int  nchk = 0, nbad = 0;
    bit  finished = 0;

    // ---------------- flash model ----------------
    logic [7:0] lb [0:63];
    int  lcnt = 0, bitc = 0, ncs = 0, ncs_seen = 0, nrise = 0, nstat = 0, busy_until = 0;
    logic [7:0] sh = '0, mtx = 8'hFF;
    bit  wel = 0;
    time last_rise = 0, per = 0;

    function automatic logic [7:0] pat(input logic [23:0] a);
        logic [23:0] t;
        t = a * 24'd7 + 24'd3;
        return t[7:0];
    endfunction

    function automatic logic [7:0] reply(input int k);
        case (lb[0])
            8'h90:   return (k == 4) ? 8'hEF : (k == 5) ? 8'h14 : 8'hFF;
            8'h35:   return 8'h5A;
            8'h03:   return (k >= 4) ? pat({lb[1], lb[2], lb[3]} + 24'(k - 4)) : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    always @(negedge cs_n) ncs++;

    always @(posedge cs_n) if (lcnt == 1 && lb[0] == 8'h06) wel = 1;

    always @(posedge sck) begin
        nrise++;
        per = $time - last_rise;
        last_rise = $time;
        if (ncs != ncs_seen) begin
            ncs_seen = ncs; lcnt = 0; bitc = 0;
        end
        if (!cs_n) begin
            sh = {sh[6:0], mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                if (lcnt < 64) lb[lcnt] = sh;
                lcnt++;
                if (lb[0] == 8'h05 && lcnt == 1) begin
                    mtx = {6'b0, wel, (nstat < busy_until)};
                    nstat++;
                end else begin
                    mtx = reply(lcnt);
                end
            end
        end
    end

    always @(negedge sck) if (!cs_n) miso = mtx[7 - bitc];

    // ---------------- streams ----------------
    logic [7:0] rq [0:1023];
    logic [7:0] wq [0:1023];
    int  rn = 0, wi = 0;
    bit  stall = 0;

    assign rd_ready = !stall;
    assign wr_data  = wq[wi];

    always @(posedge clk) if (rd_valid && rd_ready) begin
        rq[rn] <= rd_data;
        rn <= rn + 1;
    end

    always @(posedge clk) if (wr_valid && wr_ready) wi <= wi + 1;

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [23:0] a, input int len);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = op; req_addr = a; req_len = 16'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [2:0] e);
        int t = 0;
        while (!done && t < 50000) begin @(negedge clk); t++; end
        chk(done, "R12 done seen", done, 1);
        e = err;
        @(negedge clk);
        chk(!done, "R12 done one cycle", done, 0);
    endtask

    task automatic run(input logic [3:0] op, input logic [23:0] a, input int len,
                       output logic [2:0] e, output int frames);
        int c0 = ncs;
        send(op, a, len);
        wait_done(e);
        repeat (4) @(negedge clk);
        frames = ncs - c0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        chk(req_ready == 1'b1, "R12 reset ready", req_ready, 1);
        chk(cs_n == 1'b1, "R3 reset cs_n", cs_n, 1);
        chk(sck == 1'b0, "R11 reset sck", sck, 0);
        chk(done == 1'b0, "R12 reset done", done, 0);
    endtask

    task automatic t_id;
        logic [2:0] e; int f; int r0 = rn;
        logic [7:0] exp_b [0:5] = '{8'h90, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF};
        run(OP_ID, 24'h123456, 0, e, f);
        chk(e == RES_OK, "R1 id result", e, 0);
        chk(f == 1 && lcnt == 6, "R3 id one frame of 6 bytes", f * 100 + lcnt, 106);
        for (int i = 0; i < 6; i++) chk(lb[i] == exp_b[i], "R2 id byte", lb[i], exp_b[i]);
        chk(rn - r0 == 2, "R7 id stream count", rn - r0, 2);
        chk(rq[r0] == 8'hEF && rq[r0+1] == 8'h14, "R7 id bytes", {rq[r0], rq[r0+1]}, 16'hEF14);
    endtask

    task automatic t_status;
        logic [2:0] e; int f; int r0;
        run(OP_WREN, 24'h0, 0, e, f);
        chk(f == 1 && lcnt == 1 && lb[0] == 8'h06, "R1 write enable byte", lb[0], 8'h06);
        r0 = rn;
        run(OP_STAT1, 24'h0, 0, e, f);
        chk(lcnt == 2 && lb[0] == 8'h05 && lb[1] == 8'hFF, "R7 status1 frame", lb[0], 8'h05);
        chk(rq[r0] == 8'h02, "R7 status1 latch bit", rq[r0], 8'h02);
        r0 = rn;
        run(OP_STAT2, 24'h0, 0, e, f);
        chk(lb[0] == 8'h35 && rq[r0] == 8'h5A, "R1 status2", rq[r0], 8'h5A);
    endtask

    task automatic t_read_stall;
        logic [2:0] e; int r0 = rn; int c0 = ncs; int n0; int t = 0;
        logic [7:0] exp_b [0:3] = '{8'h03, 8'h01, 8'h23, 8'h45};
        stall = 1;
        send(OP_READ, 24'h012345, 3);
        while (!rd_valid && t < 5000) begin @(negedge clk); t++; end
        n0 = nrise;
        repeat (200) @(negedge clk);
        chk(nrise == n0, "R8 sck stalled", nrise - n0, 0);
        chk(cs_n == 1'b0, "R3 cs held during stall", cs_n, 0);
        stall = 0;
        wait_done(e);
        repeat (4) @(negedge clk);
        chk(e == RES_OK && ncs - c0 == 1, "R3 read one frame", ncs - c0, 1);
        chk(lcnt == 7, "R3 read byte count", lcnt, 7);
        for (int i = 0; i < 4; i++) chk(lb[i] == exp_b[i], "R2 read header", lb[i], exp_b[i]);
        for (int i = 4; i < 7; i++) chk(lb[i] == 8'hFF, "R7 read dummy", lb[i], 8'hFF);
        chk(rn - r0 == 3, "R7 read count", rn - r0, 3);
        for (int i = 0; i < 3; i++)
            chk(rq[r0+i] == pat(24'h012345 + 24'(i)), "R7 read data", rq[r0+i], pat(24'h012345 + 24'(i)));
        chk(per == 60, "R11 sck period div 6", int'(per), 60);
    endtask

    task automatic t_prog;
        logic [2:0] e; int f; int w0 = wi;
        for (int i = 0; i < 16; i++) wq[w0+i] = 8'(i * 3 + 1);
        wr_valid = 1'b1;
        run(OP_PROG, 24'h0000F0, 16, e, f);
        chk(e == RES_OK && f == 1, "R4 page fits", e, 0);
        chk(lcnt == 20 && lb[0] == 8'h02 && lb[3] == 8'hF0, "R2 program header", lb[3], 8'hF0);
        for (int i = 0; i < 16; i++) chk(lb[4+i] == 8'(i * 3 + 1), "R9 program data", lb[4+i], i * 3 + 1);
        chk(wi - w0 == 16, "R9 handshakes", wi - w0, 16);
        run(OP_PROG, 24'h0000F1, 16, e, f);
        chk(e == RES_PAGE && f == 0, "R4 page crossing rejected", e, RES_PAGE);
        chk(wi - w0 == 16, "R4 no bytes taken", wi - w0, 16);
        wr_valid = 1'b0;
    endtask

    task automatic t_len0;
        logic [2:0] e; int f;
        run(OP_READ, 24'h000100, 0, e, f);
        chk(e == RES_LEN && f == 0, "R6 read zero length", e, RES_LEN);
        run(OP_PROG, 24'h000100, 0, e, f);
        chk(e == RES_LEN && f == 0, "R6 program zero length", e, RES_LEN);
    endtask

    task automatic t_erase;
        logic [2:0] e; int f;
        run(OP_ER4K, 24'h001001, 0, e, f);
        chk(e == RES_ALIGN && f == 0, "R5 4k misaligned", e, RES_ALIGN);
        run(OP_ER4K, 24'h002000, 0, e, f);
        chk(e == RES_OK && lcnt == 4 && lb[0] == 8'h20 && lb[2] == 8'h20, "R5 4k aligned", lb[0], 8'h20);
        run(OP_ER32K, 24'h008000, 0, e, f);
        chk(e == RES_OK && lb[0] == 8'h52 && lb[1] == 8'h00 && lb[2] == 8'h80, "R2 32k erase", lb[2], 8'h80);
        run(OP_ER64K, 24'h008000, 0, e, f);
        chk(e == RES_ALIGN && f == 0, "R5 64k misaligned", e, RES_ALIGN);
        run(OP_ER64K, 24'h030000, 0, e, f);
        chk(e == RES_OK && lb[0] == 8'hD8 && lb[1] == 8'h03 && lb[3] == 8'h00, "R2 64k erase", lb[1], 8'h03);
        run(OP_ERCHIP, 24'h0, 0, e, f);
        chk(e == RES_OK && f == 1 && lcnt == 1 && lb[0] == 8'hC7, "R1 chip erase", lb[0], 8'hC7);
        run(4'd12, 24'h0, 1, e, f);
        chk(e == RES_BADOP && f == 0, "R12 bad op", e, RES_BADOP);
    endtask

    task automatic t_poll;
        logic [2:0] e; int f; int r0 = rn;
        busy_until = nstat + 2;
        run(OP_POLL, 24'h0, 0, e, f);
        chk(e == RES_OK && f == 3, "R10 poll clears on third read", f, 3);
        chk(rn == r0, "R10 poll off stream", rn - r0, 0);
        busy_until = nstat + 100;
        run(OP_POLL, 24'h0, 0, e, f);
        chk(e == RES_TIMEOUT && f == 5, "R10 poll timeout", e * 100 + f, RES_TIMEOUT * 100 + 5);
        busy_until = nstat;
    endtask

    task automatic t_ignore;
        logic [2:0] e; int c0 = ncs; int t = 0;
        send(OP_READ, 24'h000010, 2);
        while (cs_n && t < 100) begin @(negedge clk); t++; end
        req_op = OP_WREN; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(e);
        repeat (60) @(negedge clk);
        chk(ncs - c0 == 1 && lb[0] == 8'h03, "R12 request in flight ignored", ncs - c0, 1);
        chk(!done, "R12 no extra done", done, 0);
    endtask

    task automatic t_div;
        logic [2:0] e; int f;
        sck_div = 8'd4;
        run(OP_STAT1, 24'h0, 0, e, f);
        chk(per == 40, "R11 sck period div 4", int'(per), 40);
        sck_div = 8'd6;
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_id;
        t_status;
        t_read_stall;
        t_prog;
        t_len0;
        t_erase;
        t_poll;
        t_ignore;
        t_div;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!finished) begin
            finished = 1;
            nchk++; nbad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule